// File: doc/BRIEF.md
# Muxed-Bus Burst Read Timing Engine

This block runs read accesses on an external 16-bit memory whose address and data share one set of pins. When a request is accepted, a single cycle counter starts at zero. Each strobe edge (chip select, address valid, output enable) is placed at its own programmed count measured from that common start. During the address-valid window the block drives the request address on the shared bus. It releases the bus at least one cycle before output enable goes low. It then samples data words at programmed counts and hands each word out on a one-cycle valid strobe.

A request reads either a single word or a fixed-length burst of 4, 8 or 16 words. The first word is sampled after a read-access delay, and each later word follows a shorter page gap. A free-running memory clock starts at a programmed count and runs at a selectable fraction of the functional clock. The access closes once the programmed cycle length has elapsed and every word has been returned. All timing inputs are captured when the request is accepted.

Top module: `mbr_top`

## Requirements
- R1: `req_ready` is high only while no access is running. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Requests presented while busy are ignored and do not restart the running access.
- R2: Count k is the counter value at the k-th clock edge after the accepting edge, starting at 0. After the edge at count k, `mem_cs_n` is low exactly when cs_on <= k < cs_off.
- R3: After the edge at count k, `mem_adv_n` is low exactly when adv_on <= k < adv_off.
- R4: After the edge at count k, `mem_oe_n` is low exactly when oe_on <= k < oe_off.
- R5: After the edge at count k, `bus_drive` is high and `bus_out` carries the request address exactly when adv_on <= k < adv_off and k+1 < oe_on. The bus is therefore released at least one cycle before output enable falls.
- R6: The number of words per request is 1 when `cfg_burst_en` is 0. Otherwise `cfg_burst_len` 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words.
- R7: Word i (from 0) is sampled from `bus_in` at the edge of count rd_access + i*g, where g is `cfg_page_gap`, or 1 when that field is 0. `rd_valid` is high for the following cycle with that word on `rd_data`. `rd_last` is high with the final word only.
- R8: The access ends at the edge of count max(cycle_len, last_sample+1). After that edge `done` is high for exactly one cycle, `req_ready` is high, and all strobes are high.
- R9: Divider code 0, 1 and 2 (3 acts as 2) sets the clock factor f to 1, 2 and 3. After the edge at count k, `mem_clk` is 0 while k < clk_start. From k = clk_start on, it is 1 when floor((k-clk_start)/f) is even and 0 otherwise. It is 0 whenever no access is running.
- R10: Every timing, divider and burst input, and the address, is captured at the accepting edge. Changes made during an access have no effect on that access.
- R11: After reset, `req_ready` is 1, all strobes are 1, and `mem_clk`, `bus_drive`, `rd_valid`, `rd_last` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | read request |
| req_ready | output | 1 | idle, able to accept a request |
| req_addr | input | DW | address driven in the address phase |
| cfg_cs_on | input | TW | chip-select assert count |
| cfg_cs_off | input | TW | chip-select release count |
| cfg_adv_on | input | TW | address-valid assert count |
| cfg_adv_off | input | TW | address-valid release count |
| cfg_oe_on | input | TW | output-enable assert count |
| cfg_oe_off | input | TW | output-enable release count |
| cfg_rd_access | input | TW | count of the first data sample |
| cfg_cycle_len | input | TW | minimum access length |
| cfg_page_gap | input | PW | counts between burst words |
| cfg_clk_div | input | 2 | memory clock divider code |
| cfg_clk_start | input | TW | count of the first memory clock rise |
| cfg_burst_en | input | 1 | 0 single word, 1 burst |
| cfg_burst_len | input | 2 | burst length code |
| mem_clk | output | 1 | memory clock |
| mem_cs_n | output | 1 | chip select, active low |
| mem_adv_n | output | 1 | address valid, active low |
| mem_oe_n | output | 1 | output enable, active low |
| bus_out | output | DW | value driven on the shared bus |
| bus_drive | output | 1 | bus output enable |
| bus_in | input | DW | value read from the shared bus |
| rd_valid | output | 1 | data word valid |
| rd_data | output | DW | data word |
| rd_last | output | 1 | final word of the request |
| done | output | 1 | access finished |

## Verification
The hardest state to reach from the ports is an access whose length is set by its sample schedule rather than by the programmed cycle length. This happens in a long 16-word burst with a wide page gap and a short cycle count. The bench sets up that case, and also a zero page gap and an address window that overlaps output enable. In every access it scrambles all configuration inputs right after acceptance. In one access it holds the request high throughout, so that both configuration capture and the rejection of requests while busy are seen at the strobes.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int MAX_WORDS = 16;
  localparam int WCW = $clog2(MAX_WORDS + 1);

  function automatic logic [WCW-1:0] burst_words(input logic en, input logic [1:0] code);
    if (!en) return WCW'(1);
    case (code)
      2'd0:    return WCW'(4);
      2'd1:    return WCW'(8);
      default: return WCW'(16);
    endcase
  endfunction

  function automatic logic [1:0] clk_factor(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/mbr_window.sv
module mbr_window #(
  parameter int TW = 5,
  parameter int CNTW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            fin,
  input  logic [CNTW-1:0] cnt,
  input  logic [TW-1:0]   t_on,
  input  logic [TW-1:0]   t_off,
  output logic            strobe_n
);
  always_ff @(posedge clk) begin
    if (rst || !run || fin) strobe_n <= 1'b1;
    else strobe_n <= !((cnt >= CNTW'(t_on)) && (cnt < CNTW'(t_off)));
  end
endmodule

// File: rtl/mbr_clkgen.sv
module mbr_clkgen #(
  parameter int TW = 5,
  parameter int CNTW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            fin,
  input  logic [CNTW-1:0] cnt,
  input  logic [TW-1:0]   start_at,
  input  logic [1:0]      factor,
  output logic            mem_clk
);
  logic       going;
  logic [1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run || fin) begin
      mem_clk <= 1'b0;
      going   <= 1'b0;
      ph      <= 2'd0;
    end else if (!going) begin
      if (cnt == CNTW'(start_at)) begin
        mem_clk <= 1'b1;
        going   <= 1'b1;
        ph      <= 2'd0;
      end
    end else if (ph == factor - 2'd1) begin
      mem_clk <= !mem_clk;
      ph      <= 2'd0;
    end else begin
      ph <= ph + 2'd1;
    end
  end

  p_clk_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mem_clk);
endmodule

// File: rtl/mbr_capture.sv
module mbr_capture
  import mbr_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 5,
  parameter int PW = 4,
  parameter int CNTW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            run,
  input  logic [CNTW-1:0] cnt,
  input  logic [TW-1:0]   first_at,
  input  logic [PW-1:0]   gap,
  input  logic            burst_en,
  input  logic [1:0]      burst_code,
  input  logic [DW-1:0]   bus_in,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            all_done
);
  logic [CNTW-1:0] next_at;
  logic [PW-1:0]   gap_l;
  logic [WCW-1:0]  got, nw_l;

  assign all_done = (got == nw_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_at  <= '0;
      gap_l    <= PW'(1);
      got      <= '0;
      nw_l     <= WCW'(1);
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else if (start) begin
      next_at  <= CNTW'(first_at);
      gap_l    <= (gap == '0) ? PW'(1) : gap;
      got      <= '0;
      nw_l     <= burst_words(burst_en, burst_code);
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else if (run && (got < nw_l) && (cnt == next_at)) begin
      rd_valid <= 1'b1;
      rd_data  <= bus_in;
      rd_last  <= (got + WCW'(1) == nw_l);
      got      <= got + WCW'(1);
      next_at  <= next_at + CNTW'(gap_l);
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end
  end

  p_word_cap_r6: assert property (@(posedge clk) disable iff (rst) got <= nw_l);
  p_last_valid_r7: assert property (@(posedge clk) disable iff (rst) rd_last |-> rd_valid);
endmodule

// File: rtl/mbr_top.sv
module mbr_top
  import mbr_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 5,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  input  logic [TW-1:0] cfg_cs_on,
  input  logic [TW-1:0] cfg_cs_off,
  input  logic [TW-1:0] cfg_adv_on,
  input  logic [TW-1:0] cfg_adv_off,
  input  logic [TW-1:0] cfg_oe_on,
  input  logic [TW-1:0] cfg_oe_off,
  input  logic [TW-1:0] cfg_rd_access,
  input  logic [TW-1:0] cfg_cycle_len,
  input  logic [PW-1:0] cfg_page_gap,
  input  logic [1:0]    cfg_clk_div,
  input  logic [TW-1:0] cfg_clk_start,
  input  logic          cfg_burst_en,
  input  logic [1:0]    cfg_burst_len,
  output logic          mem_clk,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_drive,
  input  logic [DW-1:0] bus_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          done
);
  localparam int CNTW = ((TW > PW + 4) ? TW : PW + 4) + 1;
  localparam int NSTB = 3;

  logic            run, fin, start, all_done;
  logic [CNTW-1:0] cnt;
  logic [TW-1:0]   on_l [NSTB];
  logic [TW-1:0]   off_l[NSTB];
  logic [NSTB-1:0] stb_n;
  logic [TW-1:0]   cyc_l, clk_start_l;
  logic [1:0]      fac_l;
  logic [DW-1:0]   addr_l;
  logic            drive_nx;

  assign req_ready = !run;
  assign start     = !run && req_valid;
  assign fin       = run && (cnt >= CNTW'(cyc_l)) && all_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (fin) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else if (run) begin
        cnt <= cnt + CNTW'(1);
      end
    end
  end

  // timing set captured once per access
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTB; i++) begin
        on_l[i]  <= '0;
        off_l[i] <= '0;
      end
      cyc_l       <= '0;
      clk_start_l <= '0;
      fac_l       <= 2'd1;
      addr_l      <= '0;
    end else if (start) begin
      on_l[0]     <= cfg_cs_on;
      off_l[0]    <= cfg_cs_off;
      on_l[1]     <= cfg_adv_on;
      off_l[1]    <= cfg_adv_off;
      on_l[2]     <= cfg_oe_on;
      off_l[2]    <= cfg_oe_off;
      cyc_l       <= cfg_cycle_len;
      clk_start_l <= cfg_clk_start;
      fac_l       <= clk_factor(cfg_clk_div);
      addr_l      <= req_addr;
    end
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    mbr_window #(.TW(TW), .CNTW(CNTW)) u_win (
      .clk(clk), .rst(rst), .run(run), .fin(fin), .cnt(cnt),
      .t_on(on_l[g]), .t_off(off_l[g]), .strobe_n(stb_n[g])
    );
  end

  assign mem_cs_n  = stb_n[0];
  assign mem_adv_n = stb_n[1];
  assign mem_oe_n  = stb_n[2];

  assign drive_nx = run && !fin
                 && (cnt >= CNTW'(on_l[1])) && (cnt < CNTW'(off_l[1]))
                 && ((cnt + CNTW'(1)) < CNTW'(on_l[2]));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_drive <= 1'b0;
      bus_out   <= '0;
    end else begin
      bus_drive <= drive_nx;
      bus_out   <= drive_nx ? addr_l : '0;
    end
  end

  mbr_clkgen #(.TW(TW), .CNTW(CNTW)) u_clk (
    .clk(clk), .rst(rst), .run(run), .fin(fin), .cnt(cnt),
    .start_at(clk_start_l), .factor(fac_l), .mem_clk(mem_clk)
  );

  mbr_capture #(.DW(DW), .TW(TW), .PW(PW), .CNTW(CNTW)) u_cap (
    .clk(clk), .rst(rst), .start(start), .run(run), .cnt(cnt),
    .first_at(cfg_rd_access), .gap(cfg_page_gap),
    .burst_en(cfg_burst_en), .burst_code(cfg_burst_len),
    .bus_in(bus_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .all_done(all_done)
  );

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(bus_drive));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && mem_cs_n && mem_adv_n && mem_oe_n));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_clk && !bus_drive));
endmodule

// File: tb/tb_mbr_top.sv
module tb_mbr_top;
  localparam int DW = 16, TW = 5, PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [DW-1:0] req_addr = '0;
  logic [TW-1:0] cs_on = '0, cs_off = '0, adv_on = '0, adv_off = '0;
  logic [TW-1:0] oe_on = '0, oe_off = '0, rda = '0, cyc = '0, cks = '0;
  logic [PW-1:0] gap = '0;
  logic [1:0] ckd = '0, blen = '0;
  logic ben = 1'b0;
  logic mem_clk, mem_cs_n, mem_adv_n, mem_oe_n, bus_drive, rd_valid, rd_last, done;
  logic [DW-1:0] bus_out, rd_data;
  logic [DW-1:0] bus_in = '0;

  int n_checks = 0, n_fail = 0, cyc_count = 0;

  always #4 clk = !clk;

  mbr_top #(.DW(DW), .TW(TW), .PW(PW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_cs_on(cs_on), .cfg_cs_off(cs_off),
    .cfg_adv_on(adv_on), .cfg_adv_off(adv_off), .cfg_oe_on(oe_on),
    .cfg_oe_off(oe_off), .cfg_rd_access(rda), .cfg_cycle_len(cyc),
    .cfg_page_gap(gap), .cfg_clk_div(ckd), .cfg_clk_start(cks),
    .cfg_burst_en(ben), .cfg_burst_len(blen), .mem_clk(mem_clk),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .bus_out(bus_out), .bus_drive(bus_drive), .bus_in(bus_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .done(done)
  );

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc_count);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] bus_pat(input int id, input int k);
    return DW'(16'h3C00 ^ (id << 10)) + DW'(k * 7);
  endfunction

  // One access with the reference schedule built from the requirements.
  task automatic run_access(input int id, input int a, input int c_on, input int c_off,
                            input int a_on, input int a_off, input int o_on, input int o_off,
                            input int ra, input int cl, input int pg, input int dv,
                            input int ck, input int be, input int bl, input bit hold);
    int nw, g, f, s_last, k_end, got_v;
    int samp[$];
    nw = (be == 0) ? 1 : (bl == 0) ? 4 : (bl == 1) ? 8 : 16;      // R6
    g  = (pg == 0) ? 1 : pg;
    f  = (dv == 0) ? 1 : (dv == 1) ? 2 : 3;
    for (int i = 0; i < nw; i++) samp.push_back(ra + i * g);
    s_last = samp[nw-1];
    k_end  = (cl > s_last + 1) ? cl : s_last + 1;

    @(negedge clk);
    req_addr = DW'(a); cs_on = TW'(c_on); cs_off = TW'(c_off);
    adv_on = TW'(a_on); adv_off = TW'(a_off); oe_on = TW'(o_on); oe_off = TW'(o_off);
    rda = TW'(ra); cyc = TW'(cl); gap = PW'(pg); ckd = 2'(dv); cks = TW'(ck);
    ben = be[0]; blen = 2'(bl); req_valid = 1'b1;
    check("R1 ready before accept", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    // R10: scramble every configuration input once the access is running
    req_addr = ~req_addr; cs_on = ~cs_on; cs_off = ~cs_off; adv_on = ~adv_on;
    adv_off = ~adv_off; oe_on = ~oe_on; oe_off = ~oe_off; rda = ~rda; cyc = ~cyc;
    gap = ~gap; ckd = ~ckd; cks = ~cks; ben = ~ben; blen = ~blen;
    check("R1 busy after accept", int'(req_ready), 0);
    bus_in = bus_pat(id, 0);
    got_v = 0;
    for (int k = 0; k <= k_end; k++) begin
      bit e, ev;
      @(posedge clk);
      @(negedge clk);
      e  = (k == k_end);
      ev = 1'b0;
      foreach (samp[i]) if (samp[i] == k) ev = 1'b1;
      check("R2/R10 cs_n", int'(mem_cs_n), e ? 1 : int'(!(k >= c_on && k < c_off)));
      check("R3/R10 adv_n", int'(mem_adv_n), e ? 1 : int'(!(k >= a_on && k < a_off)));
      check("R4/R10 oe_n", int'(mem_oe_n), e ? 1 : int'(!(k >= o_on && k < o_off)));
      check("R5 bus_drive", int'(bus_drive),
            (!e && k >= a_on && k < a_off && k + 1 < o_on) ? 1 : 0);
      if (bus_drive) check("R5 bus_out", int'(bus_out), a & 16'hFFFF);
      check("R9 mem_clk", int'(mem_clk),
            (e || k < ck) ? 0 : ((((k - ck) / f) % 2) == 0 ? 1 : 0));
      check("R7 rd_valid", int'(rd_valid), int'(ev));
      if (ev) begin
        check("R7 rd_data", int'(rd_data), int'(bus_pat(id, k)));
        check("R7 rd_last", int'(rd_last), (k == s_last) ? 1 : 0);
        got_v++;
      end
      check("R8 done", int'(done), int'(e));
      check("R1 ready", int'(req_ready), int'(e));
      bus_in = bus_pat(id, k + 1);
    end
    check("R6 word total", got_v, nw);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 done single pulse", int'(done), 0);
    check("R1 idle", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 ready", int'(req_ready), 1);
    check("R11 cs_n", int'(mem_cs_n), 1);
    check("R11 adv_n", int'(mem_adv_n), 1);
    check("R11 oe_n", int'(mem_oe_n), 1);
    check("R11 mem_clk", int'(mem_clk), 0);
    check("R11 bus_drive", int'(bus_drive), 0);
    check("R11 rd_valid", int'(rd_valid), 0);
    check("R11 rd_last", int'(rd_last), 0);
    check("R11 done", int'(done), 0);
    //         id addr    cs    adv   oe     ra cyc gap dv ck be bl hold
    run_access(1, 16'hA5C3, 1, 12, 1, 4, 5, 11, 8, 14, 2, 1, 2, 0, 0, 0); // single
    run_access(2, 16'h1234, 0, 13, 0, 3, 4, 13, 6, 10, 2, 0, 0, 1, 0, 0); // 4 words
    run_access(3, 16'hBEEF, 2, 20, 1, 3, 3, 20, 5, 20, 0, 2, 1, 1, 1, 0); // 8, gap 0
    run_access(4, 16'h0F0F, 1, 31, 1, 5, 7, 31, 10, 31, 3, 3, 4, 1, 2, 0); // 16, long
    run_access(5, 16'h7E81, 0, 30, 0, 9, 4, 25, 4, 3, 1, 1, 0, 1, 3, 1); // code 3, held
    run_access(6, 16'h5555, 0, 0, 2, 2, 0, 0, 0, 0, 0, 0, 31, 0, 0, 0); // empty windows
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule